// File: doc/BRIEF.md
# Serial LED Shift-Latch Driver

This block drives a bank of sixteen LED pins, grouped as four ports of four LEDs, from a three-wire serial stream made of a data line, a shift clock and a strobe. Bits are clocked into an internal shift chain. The chain is copied onto the LED pins only when the strobe fires, so the pins never show partly shifted data. A two-bit length field sets how many LEDs of each port take part in the chain, from one to four. A two-bit tap field picks the port boundary whose bit is sent out on a registered serial output, so further devices can be chained behind this one. A drive bit switches every LED pin between driven and high-impedance.

The serial mode is chosen by straps that are sampled once, on the first system clock edge after reset is released. When the mode is not chosen, the LED pins carry the regular LED function values. These arrive as a plain input vector and are always driven. The shift clock, strobe and data inputs are asynchronous to the system clock. They pass through two-flop synchronisers, and the block acts on the detected rising edges of the shift clock and the strobe.

LED `k` of port `p` is bit `p*4+k` of every 16-bit LED vector.

Top module: `serial_led_driver`

## Requirements
- R1: Serial mode is selected only when `strap_clk_sel` equals 2'b10 and `strap_enable` is 1 at the first clock edge after `rst_n` rises. Any other strap combination leaves the block in pass-through mode.
- R2: In pass-through mode, `led_out` equals `normal_led`, every bit of `led_oe` is 1, and `ser_out` is 0. Shift-clock and strobe activity has no effect on the pins.
- R3: In serial mode, a rising edge on `ser_clk` shifts the synchronised `ser_data` into the chain within four system clocks. `led_out` changes only after a rising edge on `ser_strobe`, which copies the chain to the pins within four system clocks.
- R4: `cfg_len` sets the LEDs per port that are in the chain: 00 selects LED0 only, 01 selects LED0..1, 10 selects LED0..2 and 11 selects LED0..3. The order of the chain, from the bit shifted in last to the bit shifted in first, is port 0 to port 3, and within each port LED0 upward. Port 0 LED0 always receives the newest bit.
- R5: LEDs outside the active chain keep their last latched value when the strobe fires.
- R6: Out of reset, both the chain and the latched LEDs read 1 on LED0 and LED2 and 0 on LED1 and LED3 of every port (16'h5555).
- R7: `ser_out` presents the chain bit held by the highest active LED of port `cfg_tap` (00 = port 0 through 11 = port 3). It is updated in the same cycle as the chain.
- R8: In serial mode, `cfg_drive` = 0 clears all sixteen `led_oe` bits and `cfg_drive` = 1 sets all of them. Either way, the latched values are preserved.
- R9: Strap changes after the sampling edge have no effect on the mode until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_clk_sel | input | 2 | Clock-select strap, sampled after reset |
| strap_enable | input | 1 | Serial enable strap, sampled after reset |
| cfg_len | input | 2 | LEDs per port in the chain, minus one |
| cfg_tap | input | 2 | Port whose last chain bit drives `ser_out` |
| cfg_drive | input | 1 | 1 drives the LED pins, 0 tri-states them |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Shift clock, asynchronous |
| ser_strobe | input | 1 | Latch strobe, asynchronous |
| normal_led | input | 16 | Regular LED function values |
| led_out | output | 16 | LED pin values |
| led_oe | output | 16 | Per-pin output enable |
| ser_out | output | 1 | Registered cascade output |

## Verification
The assertions check on every cycle that the output enables are all set or all clear, that the chain moves only on a detected shift edge, that the latched LEDs change only on a detected strobe edge, that the sampled mode stays frozen after its sampling edge, and that the reset pattern is present at that edge. The bench's scenarios are needed to show the rest. These are the chain order and length for each `cfg_len` value, the retention of LEDs left out of the chain, the tap position seen on `ser_out`, the strap combinations that do or do not select serial mode, and the pass-through path. Each of them requires a software model of the chain to be compared against the pins.

// File: rtl/slsd_pkg.sv
package slsd_pkg;
    localparam int SLSD_PORTS = 4;
    localparam int SLSD_LEDS_PER_PORT = 4;
    localparam logic [1:0] SLSD_STRAP_SERIAL = 2'b10;
endpackage

// File: rtl/slsd_sync.sv
module slsd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;
endmodule

// File: rtl/slsd_chain.sv
module slsd_chain #(
    parameter int NP = 4,
    parameter int LP = 4,
    localparam int NL = NP * LP,
    localparam int LW = $clog2(LP),
    localparam int TW = $clog2(NP),
    localparam int IW = $clog2(NL)
) (
    input  logic [NL-1:0] cur,
    input  logic          din,
    input  logic [LW-1:0] len,
    input  logic [TW-1:0] tap,
    output logic [NL-1:0] shifted,
    output logic [NL-1:0] mask,
    output logic [IW-1:0] tap_idx
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        for (genvar i = 0; i < LP; i++) begin : g_led
            localparam int B = p * LP + i;
            assign mask[B] = (LW'(i) <= len);
            if (p == 0 && i == 0) begin : g_head
                assign shifted[B] = din;
            end else if (i > 0) begin : g_inner
                assign shifted[B] = mask[B] ? cur[B-1] : cur[B];
            end else begin : g_cross
                localparam int PB = (p - 1) * LP;
                assign shifted[B] = cur[IW'(PB) + IW'(len)];
            end
        end
    end

    assign tap_idx = IW'(tap) * IW'(LP) + IW'(len);
endmodule

// File: rtl/serial_led_driver.sv
module serial_led_driver
    import slsd_pkg::*;
#(
    parameter int NP = SLSD_PORTS,
    parameter int LP = SLSD_LEDS_PER_PORT,
    localparam int NL = NP * LP,
    localparam int LW = $clog2(LP),
    localparam int TW = $clog2(NP),
    localparam int IW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    strap_clk_sel,
    input  logic          strap_enable,
    input  logic [LW-1:0] cfg_len,
    input  logic [TW-1:0] cfg_tap,
    input  logic          cfg_drive,
    input  logic          ser_data,
    input  logic          ser_clk,
    input  logic          ser_strobe,
    input  logic [NL-1:0] normal_led,
    output logic [NL-1:0] led_out,
    output logic [NL-1:0] led_oe,
    output logic          ser_out
);
    function automatic logic [NL-1:0] reset_pattern();
        logic [NL-1:0] v;
        for (int b = 0; b < NL; b++) v[b] = ((b % LP) % 2) == 0;
        return v;
    endfunction

    localparam logic [NL-1:0] RST_PAT = reset_pattern();

    typedef struct packed {
        logic [NL-1:0] sreg;
        logic [NL-1:0] leds;
        logic          ser;
        logic          mode;
        logic          armed;
        logic          clk_prev;
        logic          stb_prev;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]    sy;
    logic [NL-1:0] shifted;
    logic [NL-1:0] mask;
    logic [IW-1:0] tap_idx;
    logic          clk_rise;
    logic          stb_rise;
    logic          mode_q;
    logic          armed_q;
    logic [NL-1:0] sreg_q;
    logic [NL-1:0] leds_q;

    slsd_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_strobe, ser_clk, ser_data}),
        .sync_out (sy)
    );

    slsd_chain #(.NP(NP), .LP(LP)) u_chain (
        .cur     (st_q.sreg),
        .din     (sy[0]),
        .len     (cfg_len),
        .tap     (cfg_tap),
        .shifted (shifted),
        .mask    (mask),
        .tap_idx (tap_idx)
    );

    assign clk_rise = st_q.mode && sy[1] && !st_q.clk_prev;
    assign stb_rise = st_q.mode && sy[2] && !st_q.stb_prev;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sy[1];
        st_d.stb_prev = sy[2];
        if (st_q.armed) begin
            st_d.mode  = (strap_clk_sel == SLSD_STRAP_SERIAL) && strap_enable;
            st_d.armed = 1'b0;
        end
        if (clk_rise) begin
            st_d.sreg = shifted;
        end
        if (stb_rise) begin
            st_d.leds = (st_q.leds & ~mask) | (st_q.sreg & mask);
        end
        st_d.ser = st_d.sreg[tap_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sreg     <= RST_PAT;
            st_q.leds     <= RST_PAT;
            st_q.ser      <= 1'b0;
            st_q.mode     <= 1'b0;
            st_q.armed    <= 1'b1;
            st_q.clk_prev <= 1'b0;
            st_q.stb_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q  = st_q.mode;
    assign armed_q = st_q.armed;
    assign sreg_q  = st_q.sreg;
    assign leds_q  = st_q.leds;

    assign led_out = mode_q ? st_q.leds : normal_led;
    assign led_oe  = mode_q ? {NL{cfg_drive}} : {NL{1'b1}};
    assign ser_out = mode_q & st_q.ser;
endmodule

// File: rtl/slsd_chk.sv
module slsd_chk #(
    parameter int NL = 16,
    parameter int LP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_q,
    input logic          armed_q,
    input logic          clk_rise,
    input logic          stb_rise,
    input logic [NL-1:0] sreg_q,
    input logic [NL-1:0] leds_q,
    input logic [NL-1:0] led_oe
);
    function automatic logic [NL-1:0] alt_pattern();
        logic [NL-1:0] v;
        for (int b = 0; b < NL; b++) v[b] = (b % 2) == 0;
        return v;
    endfunction

    localparam logic [NL-1:0] EXPECT_PAT = alt_pattern();

    // R8
    oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(led_oe) == 0) || ($countones(led_oe) == NL));

    // R3
    sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_rise |=> $stable(sreg_q));

    // R3
    leds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable(leds_q));

    // R9
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> $stable(mode_q));

    // R6
    reset_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (sreg_q == EXPECT_PAT) && (leds_q == EXPECT_PAT));
endmodule

bind serial_led_driver slsd_chk #(.NL(NL), .LP(LP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .armed_q  (armed_q),
    .clk_rise (clk_rise),
    .stb_rise (stb_rise),
    .sreg_q   (sreg_q),
    .leds_q   (leds_q),
    .led_oe   (led_oe)
);

// File: tb/serial_led_driver_bench.sv
module serial_led_driver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_clk_sel = 2'b10;
    logic        strap_enable = 1'b1;
    logic [1:0]  cfg_len = 2'b11;
    logic [1:0]  cfg_tap = 2'b11;
    logic        cfg_drive = 1'b1;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_strobe = 1'b0;
    logic [15:0] normal_led = 16'h0000;
    logic [15:0] led_out;
    logic [15:0] led_oe;
    logic        ser_out;

    int tests = 0;
    int fails = 0;
    logic [15:0] m_sreg;
    logic [15:0] m_led;

    always #2 clk = ~clk;

    serial_led_driver u_serial_led_driver (
        .clk(clk), .rst_n(rst_n), .strap_clk_sel(strap_clk_sel),
        .strap_enable(strap_enable), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
        .cfg_drive(cfg_drive), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_strobe(ser_strobe), .normal_led(normal_led), .led_out(led_out),
        .led_oe(led_oe), .ser_out(ser_out)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pos(int k, int n);
        return (k / n) * 4 + (k % n);
    endfunction

    function automatic logic [15:0] chain_mask(int n);
        logic [15:0] m = '0;
        for (int k = 0; k < 4 * n; k++) m[pos(k, n)] = 1'b1;
        return m;
    endfunction

    task automatic do_reset(logic [1:0] sel, logic en);
        @(negedge clk);
        rst_n = 1'b0;
        strap_clk_sel = sel;
        strap_enable = en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        m_sreg = 16'h5555;
        m_led = 16'h5555;
    endtask

    task automatic shift_bit(logic d);
        int n = int'(cfg_len) + 1;
        @(negedge clk);
        ser_data = d;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 4 * n - 1; k > 0; k--) m_sreg[pos(k, n)] = m_sreg[pos(k - 1, n)];
        m_sreg[0] = d;
    endtask

    task automatic strobe();
        logic [15:0] m = chain_mask(int'(cfg_len) + 1);
        @(negedge clk);
        ser_strobe = 1'b1;
        repeat (4) @(negedge clk);
        ser_strobe = 1'b0;
        repeat (4) @(negedge clk);
        m_led = (m_led & ~m) | (m_sreg & m);
    endtask

    task automatic t_reset();
        do_reset(2'b10, 1'b1);
        check("R6 reset LEDs", led_out, 16'h5555);
        check("R8 reset oe", led_oe, 16'hFFFF);
    endtask

    task automatic t_full_chain();
        logic [15:0] pat = 16'hA3C9;
        cfg_len = 2'b11;
        for (int b = 15; b >= 0; b--) shift_bit(pat[b]);
        check("R3 pins wait for strobe", led_out, 16'h5555);
        strobe();
        check("R4 len11 order", led_out, m_led);
        check("R4 newest bit at P0 LED0", {15'd0, led_out[0]}, {15'd0, pat[0]});
        check("R4 first bit at P3 LED3", {15'd0, led_out[15]}, {15'd0, pat[15]});
    endtask

    task automatic t_short_chain(logic [1:0] len, logic [15:0] pat);
        int n = int'(len) + 1;
        cfg_len = len;
        for (int b = 0; b < 4 * n; b++) shift_bit(pat[b]);
        strobe();
        check("R4 short chain order", led_out, m_led);
        check("R5 out-of-chain LEDs kept", led_out & ~chain_mask(n), m_led & ~chain_mask(n));
    endtask

    task automatic t_tap();
        cfg_len = 2'b01;
        for (int t = 0; t < 4; t++) begin
            cfg_tap = 2'(t);
            for (int b = 0; b < 5; b++) begin
                shift_bit(1'((b * 3 + t) % 2));
                check("R7 tap output", {15'd0, ser_out}, {15'd0, m_sreg[t * 4 + 1]});
            end
        end
        cfg_tap = 2'b11;
    endtask

    task automatic t_drive();
        cfg_drive = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 tri-state", led_oe, 16'h0000);
        check("R8 values kept", led_out, m_led);
        cfg_drive = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 driven", led_oe, 16'hFFFF);
    endtask

    task automatic t_strap_late();
        strap_clk_sel = 2'b00;
        strap_enable = 1'b0;
        normal_led = 16'h0F0F;
        repeat (3) @(negedge clk);
        check("R9 mode kept after strap change", led_out, m_led);
    endtask

    task automatic t_passthru(logic [1:0] sel, logic en, string req);
        do_reset(sel, en);
        normal_led = 16'h1234;
        @(negedge clk);
        check(req, led_out, 16'h1234);
        check("R2 pass-through oe", led_oe, 16'hFFFF);
        shift_bit(1'b1);
        strobe();
        check("R2 serial ignored", led_out, 16'h1234);
        check("R2 ser_out low", {15'd0, ser_out}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_full_chain();
        t_short_chain(2'b00, 16'h0005);
        t_short_chain(2'b01, 16'h00B2);
        t_short_chain(2'b10, 16'h0E6D);
        t_tap();
        t_drive();
        t_strap_late();
        t_passthru(2'b00, 1'b1, "R1 strap 00 gives pass-through");
        t_passthru(2'b10, 1'b0, "R1 enable 0 gives pass-through");
        t_passthru(2'b11, 1'b1, "R1 strap 11 gives pass-through");
        do_reset(2'b10, 1'b1);
        check("R1 serial mode selected", led_out, 16'h5555);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule